// File: doc/BRIEF.md
# ND to NZ Fractal Layout Reorderer

This block takes one matrix streamed element by element in row-major order and streams it back out in a tiled layout. The matrix is divided into fractals of `H0` rows by `W0` columns. The row count is padded up to a multiple of `H0`, and the column count is padded up to a multiple of `W0`.

The output walks the fractal grid by columns: every fractal in one fractal column is emitted, top to bottom, before the next fractal column starts. Inside each fractal, elements are emitted row by row. Positions that fall into the padding come out as zero. Seen as a logical shape, the result is ordered (fractal column, fractal row, row in fractal, column in fractal).

A start pulse carries the runtime row and column counts. The block first captures the whole matrix into an internal buffer. It then drains the buffer through an address generator. Both sides use a valid/ready handshake, and the final output element is flagged.

Top module: `nd2nz_reorder`

## Requirements
- R1: During and right after reset, `in_ready_o`, `out_valid_o`, `out_last_o` and `size_err_o` are all low.
- R2: A start in idle with 1 <= rows <= MAX_H and 1 <= cols <= MAX_W raises `in_ready_o` from the next cycle. It stays high until rows*cols elements have been accepted.
- R3: Output begins only after the last input element has been accepted. `in_ready_o` and `out_valid_o` are never high in the same cycle.
- R4: Fractals are emitted column-major across the fractal grid. All fractal rows of fractal column 0 come before any element of fractal column 1.
- R5: Inside a fractal, elements come out row by row. For a 4x4 input of values 0..15 with 2x2 fractals, the output is 0,1,4,5,8,9,12,13,2,3,6,7,10,11,14,15.
- R6: The output count is ceil(rows/H0)*H0 * ceil(cols/W0)*W0. Every position with row >= rows or column >= cols outputs zero.
- R7: `out_last_o` is high on the final output element and on no other. The cycle after that transfer, `out_valid_o` is low and the block is idle.
- R8: A start in idle with rows or cols equal to zero or above its maximum gives a one-cycle `size_err_o` pulse in the next cycle. The block stays idle, with `in_ready_o` low.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` holds its value.
- R10: `start_i` is ignored while loading or draining. The matrix in progress is output with its original dimensions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled in idle |
| rows_i | input | $clog2(MAX_H+1) | Matrix row count for this start |
| cols_i | input | $clog2(MAX_W+1) | Matrix column count for this start |
| in_valid_i | input | 1 | Input element valid |
| in_data_i | input | DATA_W | Input element, row-major |
| in_ready_o | output | 1 | Block accepts an input element |
| out_valid_o | output | 1 | Output element valid |
| out_data_o | output | DATA_W | Output element in fractal order |
| out_last_o | output | 1 | Final output element of the matrix |
| out_ready_i | input | 1 | Downstream accepts an output element |
| size_err_o | output | 1 | One-cycle pulse on a rejected start |

## Verification
The load phase opens one cycle after an accepted start, and a rejected start shows its error pulse one cycle after the start edge. The bench therefore samples those flags at the falling edge that follows. The first output element is valid in the cycle after the last input handshake, and each further element follows in the cycle after each output handshake. The bench drives and samples at falling edges, so each handshake is judged against the values that the next rising edge will transfer. A queue of expected elements is filled when the matrix is submitted and is popped only on an output handshake. As a result, stalls inserted through `out_ready_i` move the due cycle without breaking the comparison.

// File: rtl/nd2nz_pkg.sv
package nd2nz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DRAIN = 2'd2
  } nd2nz_state_e;
endpackage

// File: rtl/nd2nz_buf.sv
module nd2nz_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nd2nz_wr_ctr.sv
module nd2nz_wr_ctr #(
  parameter int RW = 4,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [RW-1:0] rows_i,
  input  logic [CW-1:0] cols_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          last_o
);
  logic row_end, col_end;

  assign col_end = (col_o == cols_i - CW'(1));
  assign row_end = (row_o == rows_i - RW'(1));
  assign last_o  = row_end && col_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
      col_o <= '0;
    end else if (step_i) begin
      if (col_end) begin
        col_o <= '0;
        row_o <= row_end ? '0 : row_o + RW'(1);
      end else begin
        col_o <= col_o + CW'(1);
      end
    end
  end
endmodule

// File: rtl/nd2nz_rd_gen.sv
module nd2nz_rd_gen #(
  parameter int FW  = 4,
  parameter int H0  = 2,
  parameter int W0  = 2,
  parameter int PRW = 4,
  parameter int PCW = 4,
  localparam int IW = $clog2(H0 + 1),
  localparam int JW = $clog2(W0 + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic [FW-1:0]  h1_i,
  input  logic [FW-1:0]  w1_i,
  output logic [PRW-1:0] row_o,
  output logic [PCW-1:0] col_o,
  output logic           last_o
);
  // jj innermost, then ii, then fractal row, then fractal column
  logic [JW-1:0] jj_q;
  logic [IW-1:0] ii_q;
  logic [FW-1:0] fr_q, fc_q;
  logic jj_end, ii_end, fr_end, fc_end;

  assign jj_end = (jj_q == JW'(W0 - 1));
  assign ii_end = (ii_q == IW'(H0 - 1));
  assign fr_end = (fr_q == h1_i - FW'(1));
  assign fc_end = (fc_q == w1_i - FW'(1));
  assign last_o = jj_end && ii_end && fr_end && fc_end;

  assign row_o = PRW'(32'(fr_q) * H0 + 32'(ii_q));
  assign col_o = PCW'(32'(fc_q) * W0 + 32'(jj_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jj_q <= '0;
      ii_q <= '0;
      fr_q <= '0;
      fc_q <= '0;
    end else if (step_i) begin
      jj_q <= jj_end ? '0 : jj_q + JW'(1);
      if (jj_end) begin
        ii_q <= ii_end ? '0 : ii_q + IW'(1);
        if (ii_end) begin
          fr_q <= fr_end ? '0 : fr_q + FW'(1);
          if (fr_end) fc_q <= fc_end ? '0 : fc_q + FW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/nd2nz_reorder.sv
module nd2nz_reorder #(
  parameter int DATA_W = 8,
  parameter int MAX_H  = 8,
  parameter int MAX_W  = 8,
  parameter int H0     = 2,
  parameter int W0     = 2,
  localparam int RW    = $clog2(MAX_H + 1),
  localparam int CW    = $clog2(MAX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RW-1:0]     rows_i,
  input  logic [CW-1:0]     cols_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  input  logic              out_ready_i,
  output logic              size_err_o
);
  import nd2nz_pkg::*;

  localparam int DEPTH = MAX_H * MAX_W;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(((MAX_H > MAX_W) ? MAX_H : MAX_W) + 1);
  localparam int PRW   = $clog2(MAX_H + H0);
  localparam int PCW   = $clog2(MAX_W + W0);

  nd2nz_state_e  state_q;
  logic [RW-1:0] rows_q;
  logic [CW-1:0] cols_q;
  logic [FW-1:0] h1_q, w1_q;
  logic          err_q;

  logic          size_bad, in_fire, out_fire;
  logic [RW-1:0] wr_row;
  logic [CW-1:0] wr_col;
  logic          wr_last;
  logic [PRW-1:0] rd_row;
  logic [PCW-1:0] rd_col;
  logic          rd_last, rd_pad;
  logic [AW-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata;

  assign size_bad = (rows_i == '0) || (cols_i == '0) ||
                    (32'(rows_i) > MAX_H) || (32'(cols_i) > MAX_W);

  assign in_ready_o  = (state_q == ST_LOAD);
  assign out_valid_o = (state_q == ST_DRAIN);
  assign in_fire     = in_ready_o && in_valid_i;
  assign out_fire    = out_valid_o && out_ready_i;
  assign size_err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rows_q  <= '0;
      cols_q  <= '0;
      h1_q    <= '0;
      w1_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (size_bad) begin
            err_q <= 1'b1;
          end else begin
            rows_q  <= rows_i;
            cols_q  <= cols_i;
            h1_q    <= FW'((32'(rows_i) + H0 - 1) / H0);
            w1_q    <= FW'((32'(cols_i) + W0 - 1) / W0);
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD:  if (in_fire && wr_last) state_q <= ST_DRAIN;
        ST_DRAIN: if (out_fire && rd_last) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  nd2nz_wr_ctr #(.RW(RW), .CW(CW)) u_wr (
    .clk_i, .rst_ni,
    .step_i (in_fire),
    .rows_i (rows_q),
    .cols_i (cols_q),
    .row_o  (wr_row),
    .col_o  (wr_col),
    .last_o (wr_last)
  );

  nd2nz_rd_gen #(.FW(FW), .H0(H0), .W0(W0), .PRW(PRW), .PCW(PCW)) u_rd (
    .clk_i, .rst_ni,
    .step_i (out_fire),
    .h1_i   (h1_q),
    .w1_i   (w1_q),
    .row_o  (rd_row),
    .col_o  (rd_col),
    .last_o (rd_last)
  );

  assign waddr  = AW'(32'(wr_row) * MAX_W + 32'(wr_col));
  assign rd_pad = (32'(rd_row) >= 32'(rows_q)) || (32'(rd_col) >= 32'(cols_q));
  assign raddr  = rd_pad ? '0 : AW'(32'(rd_row) * MAX_W + 32'(rd_col));

  nd2nz_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i,
    .we_i    (in_fire),
    .waddr_i (waddr),
    .wdata_i (in_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign out_data_o = rd_pad ? '0 : rdata;
  assign out_last_o = out_valid_o && rd_last;
endmodule

// File: rtl/nd2nz_reorder_chk.sv
module nd2nz_reorder_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_last_o,
  input logic              out_ready_i,
  input logic              size_err_o
);
  AST_NO_LOAD_WHILE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o); // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R9
  AST_LAST_IS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R7
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_last_o && out_ready_i) |=> !out_valid_o); // R7
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_err_o |=> !size_err_o); // R8
  AST_ERR_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_err_o |-> (!in_ready_o && !out_valid_o)); // R8
endmodule

bind nd2nz_reorder nd2nz_reorder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/nd2nz_reorder_bench.sv
module nd2nz_reorder_bench;
  localparam int DATA_W = 8;
  localparam int MAX_H  = 8;
  localparam int MAX_W  = 8;
  localparam int H0     = 2;
  localparam int W0     = 2;
  localparam int RW     = $clog2(MAX_H + 1);
  localparam int CW     = $clog2(MAX_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [RW-1:0] rows = '0;
  logic [CW-1:0] cols = '0;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_last, size_err;
  logic out_ready = 1'b1;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string cur_tag = "R4";
  bit stall_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nd2nz_reorder #(.DATA_W(DATA_W), .MAX_H(MAX_H), .MAX_W(MAX_W), .H0(H0), .W0(W0))
  u_nd2nz_reorder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rows_i(rows), .cols_i(cols),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_ready_i(out_ready), .size_err_o(size_err)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_mat(int h, int w, int base, string tag, bit lit, int poke);
    int idx;
    int h1, w1;
    h1 = (h + H0 - 1) / H0;
    w1 = (w + W0 - 1) / W0;
    cur_tag = tag;
    if (lit) begin
      // R5 literal sequence for 4x4, 2x2 fractals
      exp_q = '{0, 1, 4, 5, 8, 9, 12, 13, 2, 3, 6, 7, 10, 11, 14, 15};
    end else begin
      for (int fc = 0; fc < w1; fc++)
        for (int fr = 0; fr < h1; fr++)
          for (int i = 0; i < H0; i++)
            for (int j = 0; j < W0; j++) begin
              int r, c;
              r = fr * H0 + i;
              c = fc * W0 + j;
              exp_q.push_back((r < h && c < w) ? ((base + r * w + c) & 8'hff) : 0);
            end
    end
    @(negedge clk);
    start = 1'b1; rows = RW'(h); cols = CW'(w);
    @(negedge clk);
    start = 1'b0;
    #1 chk(in_ready == 1'b1, "R2 in_ready after start", int'(in_ready), 1);
    idx = 0;
    while (idx < h * w) begin
      in_valid = 1'b1;
      in_data  = DATA_W'(base + idx);
      if (idx == poke) begin
        start = 1'b1; rows = RW'(1); cols = CW'(1); // R10 stray start
      end else begin
        start = 1'b0;
      end
      #1;
      if (in_ready) idx++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    start = 1'b0;
    #1 chk(in_ready == 1'b0, "R3 load closed after capture", int'(in_ready), 0);
    chk(out_valid == 1'b1, "R3 drain after capture", int'(out_valid), 1);
    while (exp_q.size() != 0) @(negedge clk);
    #2 chk(out_valid == 1'b0, "R7 idle after last", int'(out_valid), 0);
  endtask

  task automatic reject(int h, int w);
    @(negedge clk);
    start = 1'b1; rows = RW'(h); cols = CW'(w);
    @(negedge clk);
    start = 1'b0;
    #1 chk(size_err == 1'b1, "R8 error pulse", int'(size_err), 1);
    chk(in_ready == 1'b0, "R8 stays idle", int'(in_ready), 0);
    @(negedge clk);
    #1 chk(size_err == 1'b0, "R8 pulse one cycle", int'(size_err), 0);
    chk(in_ready == 1'b0, "R8 no load", int'(in_ready), 0);
  endtask

  // monitor / scoreboard
  initial begin
    int cyc;
    bit hold_v;
    int hold_d;
    cyc = 0; hold_v = 0; hold_d = 0;
    forever begin
      @(negedge clk);
      out_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
      cyc++;
      #1;
      if (rst_n) begin
        if (out_valid) chk(!in_ready, "R3 no overlap", int'(in_ready), 0);
        if (hold_v) chk(out_valid && (int'(out_data) == hold_d), "R9 hold",
                        int'(out_data), hold_d);
        hold_v = out_valid && !out_ready;
        hold_d = int'(out_data);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 extra output", int'(out_data), -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(out_data) == e, cur_tag, int'(out_data), e);
            chk(out_last == (exp_q.size() == 0), "R7 last flag",
                int'(out_last), int'(exp_q.size() == 0));
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(!in_ready && !out_valid && !out_last && !size_err, "R1 reset state",
           int'({in_ready, out_valid, out_last, size_err}), 0);
    rst_n = 1'b1;
    run_mat(4, 4, 0, "R5 order in fractal", 1'b1, -1);
    stall_en = 1'b1;
    run_mat(3, 5, 1, "R6 padding", 1'b0, -1);
    run_mat(8, 8, 2, "R4 fractal column order", 1'b0, -1);
    stall_en = 1'b0;
    run_mat(1, 1, 7, "R7 single element", 1'b0, -1);
    reject(9, 3);
    reject(4, 0);
    run_mat(5, 3, 20, "R10 start ignored while busy", 1'b0, 4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule